// File: doc/BRIEF.md
# Peripheral Port Register File

This block holds the data latches and direction masks for three parallel peripheral ports: two controller ports and one extension port. The main processor reaches it through a chip select, a lower-lane data strobe, separate write and read qualifiers, and the low address lines. Only the low byte lane of the data bus is wired in, so a write lands only when the lower strobe is active: a word write and an odd-address byte write both update the addressed register, and an even-address byte write is dropped.

Each port has an output latch and a direction mask. A mask bit of one makes that pin an output driven from the latch. A mask bit of zero leaves the pin as an input. A read of a data register mixes the two per bit, returning the latch bit for output pins and the live external pin for input pins. Sixteen register slots are decoded from four address bits, and the rest of the 256-byte window repeats that set. Slots that are not assigned read as zero and take no writes.

Top module: `pport_regfile`

## Requirements
- R1: The register slot is taken from bus_addr[4:1] (byte address bits 4 to 1). bus_addr[7:5] are ignored, so byte offsets 0x20 to 0xFF repeat offsets 0x00 to 0x1F.
- R2: The data latches of controller 1, controller 2 and extension sit at byte offsets 0x02, 0x04 and 0x06 (slots 1, 2, 3). Port p's latch drives pin_out[p*8 +: 8] and is updated on the clock edge after the write.
- R3: The direction masks of the same three ports sit at byte offsets 0x08, 0x0A and 0x0C (slots 4, 5, 6). Port p's mask drives pin_oe[p*8 +: 8], where 1 means output. A read of a mask slot returns the mask.
- R4: A register is written on a rising clock edge only when cs, wr and lo_stb are all high. With lo_stb low, which is an even-address byte write, nothing changes.
- R5: Only the low data byte bus_dlo is connected. A word write, made with lo_stb high at an even address, and an odd-address byte write give the same result for the same slot.
- R6: Slots 0 and 7 to 15 read as 0x00, and writes to them change no register.
- R7: A read of a data slot returns (latch AND mask) OR (pin_in AND NOT mask), per bit, for that port.
- R8: rdata is combinational and is valid in the same cycle that cs and rd are high. At any other time it is 0x00.
- R9: The reset is synchronous and active low. It clears all latches and masks to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Block select from the address decoder |
| lo_stb | input | 1 | Lower-lane data strobe (odd byte or word) |
| wr | input | 1 | Write cycle qualifier |
| rd | input | 1 | Read cycle qualifier |
| bus_addr | input | 7 | Byte address bits 7 to 1 |
| bus_dlo | input | 8 | Low data byte for writes |
| rdata | output | 8 | Read data, low byte |
| pin_in | input | 24 | External pin levels, port p at [p*8 +: 8] |
| pin_out | output | 24 | Output latches, port p at [p*8 +: 8] |
| pin_oe | output | 24 | Direction masks, 1 = output |

## Verification
The assertions assume that every bus input is at a defined level at each clock edge and that rst_n is low at the first edge. They also assume that a write cycle presents a stable address and data for the whole edge on which it lands. The read properties relate rdata to the port outputs within the same cycle, so they assume pin_in changes only between edges. The bench keeps to these assumptions by holding reset from time zero, driving every input only on falling edges, and holding pin_in constant while reads are in progress.

// File: rtl/pport_pkg.sv
// Package: shared constants for the peripheral port register file.
// Assumes the slot layout is fixed by software expectations: data slots
// start at 1, mask slots start at 4, three ports in order.
package pport_pkg;
    localparam int NPORTS    = 3;
    localparam int DW        = 8;
    localparam int IDX_W     = 4;
    localparam int DATA_BASE = 1;
    localparam int CTRL_BASE = 4;

    typedef logic [IDX_W-1:0] slot_t;
endpackage

// File: rtl/pport_strobe.sv
// Module: forms the qualified write and read enables from bus controls.
// Assumes all inputs are synchronous to the register clock.
module pport_strobe (
    input  logic cs,
    input  logic lo_stb,
    input  logic wr,
    input  logic rd,
    output logic wr_lo,
    output logic rd_en
);
    // Lower-lane write: select, write qualifier and lower strobe together.
    always_comb begin
        wr_lo = cs & wr & lo_stb;
        rd_en = cs & rd;
    end
endmodule

// File: rtl/pport_port.sv
// Module: one port's output latch and direction mask, plus its read view.
// Assumes write enables are already decoded to this port and are one-hot.
module pport_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_data,
    input  logic         we_ctrl,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] data_q,
    output logic [W-1:0] ctrl_q,
    output logic [W-1:0] rd_mix
);
    // Latch update, cleared by synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            ctrl_q <= '0;
        end else begin
            if (we_data) data_q <= wdata;
            if (we_ctrl) ctrl_q <= wdata;
        end
    end

    // Per-pin read view: latch for outputs, pin level for inputs.
    always_comb begin
        rd_mix = (data_q & ctrl_q) | (pin_in & ~ctrl_q);
    end
endmodule

// File: rtl/pport_rdmux.sv
// Module: read-data selector across the slot map.
// Assumes slot numbers outside the data and mask ranges are unassigned.
module pport_rdmux
    import pport_pkg::*;
#(
    parameter int NP = NPORTS,
    parameter int W  = DW
) (
    input  logic                 rd_en,
    input  slot_t                slot,
    input  logic [NP-1:0][W-1:0] mix_v,
    input  logic [NP-1:0][W-1:0] ctrl_v,
    output logic [W-1:0]         rdata
);
    // Choose the slot value; zero when idle or unassigned.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            for (int p = 0; p < NP; p++) begin
                if (slot == slot_t'(DATA_BASE + p)) rdata = mix_v[p];
                if (slot == slot_t'(CTRL_BASE + p)) rdata = ctrl_v[p];
            end
        end
    end
endmodule

// File: rtl/pport_regfile.sv
// Module: top of the peripheral port register file.
// Assumes a bus with the low byte lane only; address bits above 4 mirror.
module pport_regfile
    import pport_pkg::*;
#(
    parameter int NP = NPORTS,
    parameter int W  = DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          lo_stb,
    input  logic          wr,
    input  logic          rd,
    input  logic [7:1]    bus_addr,
    input  logic [W-1:0]  bus_dlo,
    output logic [W-1:0]  rdata,
    input  logic [NP*W-1:0] pin_in,
    output logic [NP*W-1:0] pin_out,
    output logic [NP*W-1:0] pin_oe
);
    logic                 wr_lo;
    logic                 rd_en;
    slot_t                slot;
    logic                 addr_unused;
    logic [NP-1:0][W-1:0] mix_v;
    logic [NP-1:0][W-1:0] ctrl_v;
    logic [NP-1:0][W-1:0] data_v;

    // Slot decode; upper address bits are mirrors and only reduced away.
    always_comb begin
        slot        = bus_addr[4:1];
        addr_unused = ^bus_addr[7:5];
    end

    pport_strobe u_stb (
        .cs(cs), .lo_stb(lo_stb), .wr(wr), .rd(rd),
        .wr_lo(wr_lo), .rd_en(rd_en)
    );

    for (genvar p = 0; p < NP; p++) begin : g_port
        logic we_d, we_c;
        // Per-port write decode against its data and mask slots.
        always_comb begin
            we_d = wr_lo && (slot == slot_t'(DATA_BASE + p));
            we_c = wr_lo && (slot == slot_t'(CTRL_BASE + p));
        end

        pport_port #(.W(W)) u_port (
            .clk(clk), .rst_n(rst_n),
            .we_data(we_d), .we_ctrl(we_c),
            .wdata(bus_dlo),
            .pin_in(pin_in[p*W +: W]),
            .data_q(data_v[p]), .ctrl_q(ctrl_v[p]), .rd_mix(mix_v[p])
        );

        assign pin_out[p*W +: W] = data_v[p];
        assign pin_oe[p*W +: W]  = ctrl_v[p];
    end

    pport_rdmux #(.NP(NP), .W(W)) u_rd (
        .rd_en(rd_en), .slot(slot),
        .mix_v(mix_v), .ctrl_v(ctrl_v), .rdata(rdata)
    );
endmodule

// File: rtl/pport_regfile_chk.sv
// Module: assertion checker for pport_regfile, attached by bind.
// Assumes it sees only the top-level ports.
module pport_regfile_chk
    import pport_pkg::*;
#(
    parameter int NP = NPORTS,
    parameter int W  = DW
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cs,
    input logic            lo_stb,
    input logic            wr,
    input logic            rd,
    input logic [7:1]      bus_addr,
    input logic [W-1:0]    bus_dlo,
    input logic [W-1:0]    rdata,
    input logic [NP*W-1:0] pin_in,
    input logic [NP*W-1:0] pin_out,
    input logic [NP*W-1:0] pin_oe
);
    logic unassigned;
    // Slot is outside both the data and the mask ranges.
    always_comb begin
        unassigned = (bus_addr[4:1] == 4'd0) || (bus_addr[4:1] > 4'(CTRL_BASE + NP - 1));
    end

    AST_EVEN_BYTE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && !lo_stb) |=> ($stable(pin_out) && $stable(pin_oe))); // R4

    AST_UNASSIGNED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && lo_stb && unassigned) |=> ($stable(pin_out) && $stable(pin_oe))); // R6

    AST_UNASSIGNED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && unassigned) |-> (rdata == '0)); // R6

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && rd) |-> (rdata == '0)); // R8

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (pin_out == '0 && pin_oe == '0)); // R9

    for (genvar p = 0; p < NP; p++) begin : g_chk
        AST_DATA_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
            (cs && wr && lo_stb && bus_addr[4:1] == 4'(DATA_BASE + p))
            |=> (pin_out[p*W +: W] == $past(bus_dlo))); // R2

        AST_MASK_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
            (cs && wr && lo_stb && bus_addr[4:1] == 4'(CTRL_BASE + p))
            |=> (pin_oe[p*W +: W] == $past(bus_dlo))); // R3

        AST_MASK_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
            (cs && rd && bus_addr[4:1] == 4'(CTRL_BASE + p))
            |-> (rdata == pin_oe[p*W +: W])); // R3

        AST_DATA_READ_MIX: assert property (@(posedge clk) disable iff (!rst_n)
            (cs && rd && bus_addr[4:1] == 4'(DATA_BASE + p))
            |-> (rdata == ((pin_out[p*W +: W] & pin_oe[p*W +: W]) |
                           (pin_in[p*W +: W] & ~pin_oe[p*W +: W])))); // R7
    end
endmodule

bind pport_regfile pport_regfile_chk #(.NP(NP), .W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs(cs), .lo_stb(lo_stb), .wr(wr), .rd(rd),
    .bus_addr(bus_addr), .bus_dlo(bus_dlo), .rdata(rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/pport_regfile_test.sv
module pport_regfile_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0, lo_stb = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [7:1]  bus_addr = '0;
    logic [7:0]  bus_dlo = '0;
    logic [7:0]  rdata;
    logic [23:0] pin_in = {8'hC3, 8'h5A, 8'hA5};
    logic [23:0] pin_out, pin_oe;
    int          nchk = 0, nfail = 0;

    always #5 clk = ~clk;

    pport_regfile uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .lo_stb(lo_stb), .wr(wr), .rd(rd),
        .bus_addr(bus_addr), .bus_dlo(bus_dlo), .rdata(rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // Vector: {op[3:0], byte addr[7:0], data[7:0], expect[7:0], req[3:0]}
    // op 0 = lower-lane write, 1 = even-byte write (lo_stb low), 2 = read check
    localparam int NV = 26;
    localparam logic [31:0] VEC [0:NV-1] = '{
        {4'h2, 8'h02, 8'h00, 8'hA5, 4'd7},  // R7 all inputs, port 0
        {4'h2, 8'h04, 8'h00, 8'h5A, 4'd7},  // R7 port 1
        {4'h2, 8'h06, 8'h00, 8'hC3, 4'd7},  // R7 port 2
        {4'h0, 8'h03, 8'hF0, 8'h00, 4'd2},  // R2 latch port 0
        {4'h2, 8'h02, 8'h00, 8'hA5, 4'd7},  // R7 mask zero hides latch
        {4'h0, 8'h09, 8'h0F, 8'h00, 4'd3},  // R3 mask port 0
        {4'h2, 8'h08, 8'h00, 8'h0F, 4'd3},  // R3 readback
        {4'h2, 8'h02, 8'h00, 8'hA0, 4'd7},  // R7 mixed
        {4'h1, 8'h08, 8'hFF, 8'h00, 4'd4},  // R4 even byte dropped
        {4'h2, 8'h08, 8'h00, 8'h0F, 4'd4},  // R4 unchanged
        {4'h0, 8'h2B, 8'hFF, 8'h00, 4'd1},  // R1 mirror write to mask port 1
        {4'h2, 8'h0A, 8'h00, 8'hFF, 4'd1},  // R1
        {4'h2, 8'hE4, 8'h00, 8'h00, 4'd1},  // R1 mirror read data port 1
        {4'h0, 8'h0D, 8'h3C, 8'h00, 4'd3},  // R3 mask port 2
        {4'h0, 8'h07, 8'h99, 8'h00, 4'd2},  // R2 latch port 2
        {4'h2, 8'h06, 8'h00, 8'hDB, 4'd7},  // R7 mixed port 2
        {4'h0, 8'h00, 8'h77, 8'h00, 4'd6},  // R6 slot 0 write
        {4'h2, 8'h00, 8'h00, 8'h00, 4'd6},  // R6
        {4'h0, 8'h1F, 8'h55, 8'h00, 4'd6},  // R6 slot 15 write
        {4'h2, 8'h1E, 8'h00, 8'h00, 4'd6},  // R6
        {4'h2, 8'h0E, 8'h00, 8'h00, 4'd6},  // R6 slot 7
        {4'h0, 8'h0C, 8'h0F, 8'h00, 4'd5},  // R5 word write, even address
        {4'h2, 8'h0D, 8'h00, 8'h0F, 4'd5},  // R5
        {4'h2, 8'h06, 8'h00, 8'hC9, 4'd5},  // R5 new mask in effect
        {4'h2, 8'h04, 8'h00, 8'h00, 4'd2},  // R2 port 1 latch still zero
        {4'h2, 8'h0C, 8'h00, 8'h0F, 4'd3}   // R3
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d, input logic lo);
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; lo_stb = lo; bus_addr = a[7:1]; bus_dlo = d;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0; lo_stb = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; bus_addr = a[7:1];
        #1 d = rdata;
        @(negedge clk);
        cs = 1'b0; rd = 1'b0;
    endtask

    initial begin
        #1_000_000;
        nfail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R9 reset state and R8 idle read
        check("R9", {8'h0, pin_out}, {8'h0, 24'h0});
        check("R9", {8'h0, pin_oe}, {8'h0, 24'h0});
        check("R8", {24'h0, rdata}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [31:0] v;
            v = VEC[i];
            if (v[31:28] == 4'h2) begin
                bus_read(v[27:20], r);
                check($sformatf("R%0d vec%0d", v[3:0], i), {24'h0, r}, {24'h0, v[11:4]});
            end else begin
                bus_write(v[27:20], v[19:12], v[31:28] == 4'h0);
            end
        end

        // R2 and R3 at the pins
        check("R2", {8'h0, pin_out}, {8'h0, 8'h99, 8'h00, 8'hF0});
        check("R3", {8'h0, pin_oe}, {8'h0, 8'h0F, 8'hFF, 8'h0F});

        // R8 read with cs low stays zero; R4 write with cs low dropped
        @(negedge clk);
        rd = 1'b1; bus_addr = 7'h04;
        #1 check("R8", {24'h0, rdata}, 32'h0);
        rd = 1'b0;
        @(negedge clk);
        wr = 1'b1; lo_stb = 1'b1; bus_addr = 7'h04; bus_dlo = 8'hAA;
        @(negedge clk);
        wr = 1'b0; lo_stb = 1'b0;
        bus_read(8'h08, r);
        check("R4", {24'h0, r}, 32'h0F);

        // R9 synchronous reset mid-run clears everything
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        check("R9", {8'h0, pin_oe}, 32'h0);
        bus_read(8'h06, r);
        check("R9", {24'h0, r}, 32'hC3);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule